// File: doc/BRIEF.md
# SPI Slave Memory Access Port

This block is an SPI slave that gives an external master read and write access to an on-chip byte memory. The memory sits behind a plain synchronous port. Each transaction starts with a 16-bit address, sent high byte first, and then a command byte whose bit 7 chooses the direction: 1 reads and 0 writes. Every byte after the command is a data byte. The address advances by one for each data byte until chip select is released.

On a read, the slave first shifts out one status byte that describes the previous transaction. The data bytes follow, each fetched from memory before its first bit leaves. When chip select rises, the completion step runs. It stores a new status word for the next transaction, loads the command register and raises a sticky interrupt flag. The flag can be cleared only by software. Two bus command codes carry no payload in their low seven bits, and for those the command register and the flag are left alone. A safe mode confines memory writes to one aligned 16-byte window. An enable input switches the whole port on and off.

Inside, a transaction state machine steps through the states `ST_IDLE`, `ST_ADDR_HI`, `ST_ADDR_LO`, `ST_CMD`, `ST_STAT`, `ST_RD_DATA` and `ST_WR_DATA`:
- `ST_IDLE` moves to `ST_ADDR_HI` on a synchronized chip-select fall while the port is enabled.
- Each completed byte moves the machine `ST_ADDR_HI` to `ST_ADDR_LO`, then to `ST_CMD`.
- From `ST_CMD` it goes to `ST_STAT` when command bit 7 is 1, or to `ST_WR_DATA` when it is 0.
- `ST_STAT` moves to `ST_RD_DATA`.
- `ST_RD_DATA` and `ST_WR_DATA` stay where they are on each further byte.
- Every state other than `ST_IDLE` returns to `ST_IDLE` when chip select rises (completion) or when the enable drops (silent abort).

Top module: `spi_mem_port`

## Requirements
- R1: Transfers use SPI mode 0, MSB first. Bytes 0 and 1 are the address (high byte, then low byte), and byte 2 is the command, which is loaded into `cmd_reg` at completion.
- R2: When command bit 7 is 1, the slave shifts out the status byte as byte 3. Data bytes then follow, read from the address and each later address in turn. The master sends don't-care bytes while reading.
- R3: When command bit 7 is 0, every complete byte after the command is written to the address and each later address in turn, one `mem_we` pulse per byte.
- R4: At completion, if at least the command byte was received and the command's low seven bits are not all zero, `cmd_reg` takes the command and `irq_flag` is set. Commands 0x80 and 0x00, and transactions shorter than three bytes, change neither `cmd_reg` nor `irq_flag`.
- R5: `irq_flag` stays set until an `irq_flag_clr` pulse arrives. `irq` is high exactly when `irq_flag` and `irq_enable` are both 1.
- R6: Status bit 7 is 1 when the previous transaction tried a memory access while `mem_ready` was 0. Such an access is not issued, and a read data byte that was not fetched goes out as 0x00.
- R7: Status bit 6 is the XOR of all bits of the data bytes fully shifted out in the previous transaction. It does not cover the status byte.
- R8: Status bit 5 is the XOR of all bits of the address bytes, the command byte and any write data bytes of the previous transaction. The don't-care bytes of a read are not included.
- R9: Status bits 4:2 hold the low three bits of the previous transaction's data byte count, or 3'b111 if that transaction had three bytes or fewer. Bits 1:0 read 0. After reset the status byte is 0x00.
- R10: While `cfg_safe` is 1, a write byte whose address lies outside the 16-byte window starting at `SAFE_BASE` (default 0x0040) is dropped. The address still advances past it.
- R11: While `cfg_enable` is 0, the slave ignores the bus. `spi_miso` stays 0, and there are no memory accesses and no status, command or flag updates.
- R12: If chip select rises in the middle of a byte, that byte is discarded: it is neither written nor counted. Completion still runs for the bytes that were finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the SPI clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Port enable |
| cfg_safe | input | 1 | Safe mode: writes only inside the window |
| irq_enable | input | 1 | Interrupt enable |
| irq_flag_clr | input | 1 | One-cycle pulse that clears the interrupt flag |
| spi_sck | input | 1 | SPI clock from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe; data is due one cycle later |
| mem_rdata | input | 8 | Memory read data |
| mem_ready | input | 1 | Memory accepts an access this cycle |
| cmd_reg | output | 8 | Last latched command |
| irq_flag | output | 1 | Sticky interrupt flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take for granted that the memory answers `mem_re` with data on the next cycle. They also assume the SPI inputs change slowly enough that each half-period of `spi_sck` covers at least two system clocks. The bench therefore drives all SPI pins on the falling system-clock edge and holds every SPI half-period for four system clocks. It keeps chip select low for a full half-period around the first and last edges. It changes `cfg_safe` and `mem_ready` only while chip select is high, so the safe-window and ready-gating properties see steady control inputs for the whole of each transaction.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    localparam int ADDR_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int CNT_W   = 3;
    localparam int TOT_W   = 3;
    localparam int TOT_SAT = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_CMD,
        ST_STAT,
        ST_RD_DATA,
        ST_WR_DATA
    } xact_state_t;

    typedef struct packed {
        logic             not_ready;
        logic             rd_par;
        logic             wr_par;
        logic [CNT_W-1:0] count;
        logic [1:0]       flash;
    } stat_t;

    function automatic logic cmd_is_silent(input logic [BYTE_W-1:0] c);
        return c[BYTE_W-2:0] == '0;
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
    import spi_mem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              mosi_s,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              miso_bit
);

    localparam int BIT_W = $clog2(BYTE_W);

    logic [BIT_W-1:0]  bit_cnt_q;
    logic [BYTE_W-2:0] rx_sr_q;
    logic [BYTE_W-1:0] tx_sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            rx_sr_q   <= '0;
            tx_sr_q   <= '0;
        end else if (!busy) begin
            bit_cnt_q <= '0;
            rx_sr_q   <= '0;
            tx_sr_q   <= '0;
        end else begin
            if (sck_rise) begin
                rx_sr_q   <= {rx_sr_q[BYTE_W-3:0], mosi_s};
                bit_cnt_q <= bit_cnt_q + BIT_W'(1);
            end
            if (sck_fall) begin
                if (bit_cnt_q == '0) tx_sr_q <= tx_byte;
                else                 tx_sr_q <= {tx_sr_q[BYTE_W-2:0], 1'b0};
            end
        end
    end

    assign byte_done = busy && sck_rise && (bit_cnt_q == BIT_W'(BYTE_W - 1));
    assign rx_byte   = {rx_sr_q, mosi_s};
    assign miso_bit  = tx_sr_q[BYTE_W-1];

endmodule

// File: rtl/spi_xact_fsm.sv
module spi_xact_fsm
    import spi_mem_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SAFE_BASE  = 16'h0040,
    parameter int                SAFE_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              safe,
    input  logic              cs_s,
    input  logic              cs_fall,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  stat_t             stat_in,
    input  logic              mem_ready,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              busy,
    output logic [BYTE_W-1:0] tx_byte,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic              done,
    output logic              done_cmd_valid,
    output logic [BYTE_W-1:0] done_cmd,
    output stat_t             done_stat
);

    localparam int WIN_LSB = $clog2(SAFE_BYTES);

    xact_state_t       state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] cmd_q;
    logic [BYTE_W-1:0] tx_q;
    logic [TOT_W-1:0]  tot_q;
    logic [CNT_W-1:0]  dcnt_q;
    logic              rpar_q, wpar_q, err_q, rd_pend_q;

    logic ending, step, start, fetch, wr_slot, in_win;

    assign busy    = (state_q != ST_IDLE);
    assign ending  = busy && (!enable || cs_s);
    assign start   = (state_q == ST_IDLE) && enable && cs_fall;
    assign step    = busy && byte_done && !ending;
    assign fetch   = step && ((state_q == ST_STAT) || (state_q == ST_RD_DATA));
    assign wr_slot = step && (state_q == ST_WR_DATA);
    assign in_win  = addr_q[ADDR_W-1:WIN_LSB] == SAFE_BASE[ADDR_W-1:WIN_LSB];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_ADDR_HI;
            end
            ST_ADDR_HI: begin
                if (ending)         state_d = ST_IDLE;
                else if (byte_done) state_d = ST_ADDR_LO;
            end
            ST_ADDR_LO: begin
                if (ending)         state_d = ST_IDLE;
                else if (byte_done) state_d = ST_CMD;
            end
            ST_CMD: begin
                if (ending)         state_d = ST_IDLE;
                else if (byte_done) state_d = rx_byte[BYTE_W-1] ? ST_STAT : ST_WR_DATA;
            end
            ST_STAT: begin
                if (ending)         state_d = ST_IDLE;
                else if (byte_done) state_d = ST_RD_DATA;
            end
            ST_RD_DATA, ST_WR_DATA: begin
                if (ending)         state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // per-transaction datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            cmd_q     <= '0;
            tx_q      <= '0;
            tot_q     <= '0;
            dcnt_q    <= '0;
            rpar_q    <= 1'b0;
            wpar_q    <= 1'b0;
            err_q     <= 1'b0;
            rd_pend_q <= 1'b0;
        end else begin
            if (rd_pend_q) begin
                tx_q      <= mem_rdata;
                rd_pend_q <= 1'b0;
            end
            if (start) begin
                tot_q     <= '0;
                dcnt_q    <= '0;
                rpar_q    <= 1'b0;
                wpar_q    <= 1'b0;
                err_q     <= 1'b0;
                tx_q      <= '0;
                rd_pend_q <= 1'b0;
            end else if (step) begin
                if (tot_q < TOT_W'(TOT_SAT)) tot_q <= tot_q + TOT_W'(1);
                case (state_q)
                    ST_ADDR_HI: begin
                        addr_q[ADDR_W-1:BYTE_W] <= rx_byte;
                        wpar_q <= wpar_q ^ (^rx_byte);
                    end
                    ST_ADDR_LO: begin
                        addr_q[BYTE_W-1:0] <= rx_byte;
                        wpar_q <= wpar_q ^ (^rx_byte);
                    end
                    ST_CMD: begin
                        cmd_q  <= rx_byte;
                        wpar_q <= wpar_q ^ (^rx_byte);
                        if (rx_byte[BYTE_W-1]) tx_q <= stat_in;
                    end
                    ST_STAT, ST_RD_DATA: begin
                        if (state_q == ST_RD_DATA) begin
                            rpar_q <= rpar_q ^ (^tx_q);
                            dcnt_q <= dcnt_q + CNT_W'(1);
                        end
                        addr_q <= addr_q + ADDR_W'(1);
                        if (mem_ready) begin
                            rd_pend_q <= 1'b1;
                        end else begin
                            err_q <= 1'b1;
                            tx_q  <= '0;
                        end
                    end
                    ST_WR_DATA: begin
                        wpar_q <= wpar_q ^ (^rx_byte);
                        dcnt_q <= dcnt_q + CNT_W'(1);
                        addr_q <= addr_q + ADDR_W'(1);
                        if (!mem_ready) err_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        mem_addr  = addr_q;
        mem_wdata = rx_byte;
        mem_re    = fetch && mem_ready;
        mem_we    = wr_slot && mem_ready && (!safe || in_win);
        tx_byte   = tx_q;

        done           = busy && enable && cs_s && (tot_q != '0);
        done_cmd       = cmd_q;
        done_cmd_valid = (tot_q >= TOT_W'(3)) && !cmd_is_silent(cmd_q);

        done_stat.not_ready = err_q;
        done_stat.rd_par    = rpar_q;
        done_stat.wr_par    = wpar_q;
        done_stat.count     = (tot_q < TOT_W'(TOT_SAT)) ? '1 : dcnt_q;
        done_stat.flash     = 2'b00;
    end

endmodule

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs
    import spi_mem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic              done_cmd_valid,
    input  logic [BYTE_W-1:0] done_cmd,
    input  stat_t             done_stat,
    input  logic              irq_enable,
    input  logic              irq_flag_clr,
    output logic [BYTE_W-1:0] cmd_reg,
    output logic              irq_flag,
    output logic              irq,
    output stat_t             stat_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q   <= '0;
            cmd_reg  <= '0;
            irq_flag <= 1'b0;
        end else begin
            if (done) stat_q <= done_stat;
            if (done && done_cmd_valid) begin
                cmd_reg  <= done_cmd;
                irq_flag <= 1'b1;
            end else if (irq_flag_clr) begin
                irq_flag <= 1'b0;
            end
        end
    end

    assign irq = irq_flag & irq_enable;

endmodule

// File: rtl/spi_mem_port.sv
module spi_mem_port
    import spi_mem_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SAFE_BASE   = 16'h0040,
    parameter int                SAFE_BYTES  = 16,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_safe,
    input  logic              irq_enable,
    input  logic              irq_flag_clr,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic [BYTE_W-1:0] cmd_reg,
    output logic              irq_flag,
    output logic              irq
);

    logic [2:0] pins_s;
    logic       sck_s, cs_s, mosi_s;
    logic       sck_d, cs_d;
    logic       sck_rise, sck_fall, cs_fall;

    logic              busy, byte_done, miso_bit;
    logic [BYTE_W-1:0] rx_byte, tx_byte;
    logic              done, done_cmd_valid;
    logic [BYTE_W-1:0] done_cmd;
    stat_t             done_stat, stat_q;

    spi_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({spi_sck, spi_cs_n, spi_mosi}),
        .dout  (pins_s)
    );

    assign sck_s  = pins_s[2];
    assign cs_s   = pins_s[1];
    assign mosi_s = pins_s[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= sck_s;
            cs_d  <= cs_s;
        end
    end

    assign sck_rise = sck_s & ~sck_d;
    assign sck_fall = ~sck_s & sck_d;
    assign cs_fall  = ~cs_s & cs_d;

    spi_shifter shifter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .mosi_s    (mosi_s),
        .tx_byte   (tx_byte),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .miso_bit  (miso_bit)
    );

    spi_xact_fsm #(
        .SAFE_BASE  (SAFE_BASE),
        .SAFE_BYTES (SAFE_BYTES)
    ) fsm_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .enable         (cfg_enable),
        .safe           (cfg_safe),
        .cs_s           (cs_s),
        .cs_fall        (cs_fall),
        .byte_done      (byte_done),
        .rx_byte        (rx_byte),
        .stat_in        (stat_q),
        .mem_ready      (mem_ready),
        .mem_rdata      (mem_rdata),
        .busy           (busy),
        .tx_byte        (tx_byte),
        .mem_addr       (mem_addr),
        .mem_wdata      (mem_wdata),
        .mem_we         (mem_we),
        .mem_re         (mem_re),
        .done           (done),
        .done_cmd_valid (done_cmd_valid),
        .done_cmd       (done_cmd),
        .done_stat      (done_stat)
    );

    spi_ctrl_regs regs_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .done           (done),
        .done_cmd_valid (done_cmd_valid),
        .done_cmd       (done_cmd),
        .done_stat      (done_stat),
        .irq_enable     (irq_enable),
        .irq_flag_clr   (irq_flag_clr),
        .cmd_reg        (cmd_reg),
        .irq_flag       (irq_flag),
        .irq            (irq),
        .stat_q         (stat_q)
    );

    assign spi_miso = cfg_enable & miso_bit;

endmodule

// File: rtl/spi_mem_port_chk.sv
module spi_mem_port_chk #(
    parameter logic [15:0] SAFE_BASE  = 16'h0040,
    parameter int          SAFE_BYTES = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_enable,
    input logic        cfg_safe,
    input logic        irq_flag_clr,
    input logic [15:0] mem_addr,
    input logic        mem_we,
    input logic        mem_re,
    input logic        mem_ready,
    input logic [7:0]  cmd_reg,
    input logic        irq_flag
);

    localparam int WIN_LSB = $clog2(SAFE_BYTES);

    a_r10_safe_window: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_safe && mem_we) |-> (mem_addr[15:WIN_LSB] == SAFE_BASE[15:WIN_LSB]));

    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_flag_clr) |=> irq_flag);

    a_r4_cmd_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_reg) |-> irq_flag);

    a_r6_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> mem_ready);

    a_r3_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |-> (!mem_we && !mem_re));

endmodule

bind spi_mem_port spi_mem_port_chk #(
    .SAFE_BASE  (SAFE_BASE),
    .SAFE_BYTES (SAFE_BYTES)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_enable   (cfg_enable),
    .cfg_safe     (cfg_safe),
    .irq_flag_clr (irq_flag_clr),
    .mem_addr     (mem_addr),
    .mem_we       (mem_we),
    .mem_re       (mem_re),
    .mem_ready    (mem_ready),
    .cmd_reg      (cmd_reg),
    .irq_flag     (irq_flag)
);

// File: tb/spi_mem_port_tb_top.sv
module spi_mem_port_tb_top;

    localparam int HP = 4;

    typedef struct packed {
        logic        rd;
        logic [15:0] addr;
        logic [7:0]  cmd;
        logic [3:0]  n;
        logic [7:0]  seed;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 16'h0010, 8'h80, 4'd1, 8'h00},
        '{1'b0, 16'h0010, 8'h05, 4'd4, 8'h31},
        '{1'b1, 16'h0010, 8'h85, 4'd4, 8'h00},
        '{1'b0, 16'h0020, 8'h00, 4'd9, 8'hA0},
        '{1'b1, 16'h0020, 8'h80, 4'd9, 8'h00},
        '{1'b0, 16'h00F0, 8'h7E, 4'd0, 8'h00},
        '{1'b1, 16'h0013, 8'hC3, 4'd0, 8'h00},
        '{1'b1, 16'h0022, 8'h81, 4'd2, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b1, cfg_safe = 1'b0, irq_enable = 1'b0, irq_flag_clr = 1'b0;
    logic        spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic        spi_miso;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_we, mem_re;
    logic        mem_ready = 1'b1;
    logic [7:0]  cmd_reg;
    logic        irq_flag, irq;

    always #4 clk = ~clk;

    spi_mem_port dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_safe(cfg_safe),
        .irq_enable(irq_enable), .irq_flag_clr(irq_flag_clr),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .cmd_reg(cmd_reg), .irq_flag(irq_flag), .irq(irq)
    );

    logic [7:0] mem_arr [256];
    logic [7:0] model   [256];
    int         we_cnt = 0;

    always @(posedge clk) begin
        if (mem_we) begin
            mem_arr[mem_addr[7:0]] <= mem_wdata;
            we_cnt <= we_cnt + 1;
        end
        if (mem_re) mem_rdata <= mem_arr[mem_addr[7:0]];
    end

    int         checks = 0, fails = 0;
    logic       finished = 1'b0;
    logic [7:0] tx_buf [16];
    logic [7:0] rx_buf [16];
    logic [7:0] exp_stat = 8'h00;
    logic [7:0] exp_cmd  = 8'h00;
    logic       exp_flag = 1'b0;

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic spi_xfer(input int nbytes, input int tail_bits);
        spi_cs_n = 1'b0;
        wait_clk(HP);
        for (int b = 0; b < nbytes; b++) begin
            for (int i = 7; i >= 0; i--) begin
                spi_mosi = tx_buf[b][i];
                wait_clk(HP);
                rx_buf[b][i] = spi_miso;
                spi_sck = 1'b1;
                wait_clk(HP);
                spi_sck = 1'b0;
            end
        end
        for (int i = 0; i < tail_bits; i++) begin
            spi_mosi = 1'b1;
            wait_clk(HP);
            spi_sck = 1'b1;
            wait_clk(HP);
            spi_sck = 1'b0;
        end
        wait_clk(HP);
        spi_cs_n = 1'b1;
        spi_mosi = 1'b0;
        wait_clk(12);
    endtask

    task automatic clr_flag();
        irq_flag_clr = 1'b1;
        wait_clk(1);
        irq_flag_clr = 1'b0;
        wait_clk(1);
        exp_flag = 1'b0;
    endtask

    task automatic run(input logic rd, input logic [15:0] a, input logic [7:0] c,
                       input int n, input logic [7:0] seed, input int tail);
        int         base;
        logic       wp, rp, err;
        logic [7:0] d;
        logic [15:0] ai;
        base = rd ? 4 : 3;
        tx_buf[0] = a[15:8];
        tx_buf[1] = a[7:0];
        tx_buf[2] = c;
        tx_buf[3] = 8'h00;
        for (int i = 0; i < n; i++)
            tx_buf[base+i] = rd ? 8'h00 : seed + 8'(i * 13);
        spi_xfer(base + n, tail);
        wp  = (^a) ^ (^c);
        rp  = 1'b0;
        err = 1'b0;
        if (rd) begin
            chk("R2 R6 R7 R8 R9 status byte", rx_buf[3], exp_stat);
            for (int i = 0; i < n; i++) begin
                ai = a + 16'(i);
                chk("R2 read data", rx_buf[4+i], model[ai[7:0]]);
                rp = rp ^ (^model[ai[7:0]]);
            end
        end else begin
            for (int i = 0; i < n; i++) begin
                d  = tx_buf[3+i];
                ai = a + 16'(i);
                wp = wp ^ (^d);
                if (!mem_ready) err = 1'b1;
                else if (!cfg_safe || ai[15:4] == 12'h004) model[ai[7:0]] = d;
            end
        end
        exp_stat = {err, rp, wp, (base + n <= 3) ? 3'b111 : 3'(n), 2'b00};
        if (c[6:0] != 7'd0) begin
            exp_cmd  = c;
            exp_flag = 1'b1;
        end
        chk("R1 R4 cmd_reg", cmd_reg, exp_cmd);
        chk("R4 irq_flag", irq_flag, exp_flag);
    endtask

    task automatic check_mem(input string tag, input logic [7:0] a);
        chk(tag, mem_arr[a], model[a]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int cnt_before;
        for (int i = 0; i < 256; i++) begin
            mem_arr[i] = 8'(i) ^ 8'h5A;
            model[i]   = 8'(i) ^ 8'h5A;
        end
        wait_clk(5);
        // reset state
        chk("R5 reset irq_flag", irq_flag, 1'b0);
        chk("R5 reset irq", irq, 1'b0);
        chk("R1 reset cmd_reg", cmd_reg, 8'h00);
        chk("R11 reset miso", spi_miso, 1'b0);
        rst_n = 1'b1;
        wait_clk(5);

        // vector table
        for (int v = 0; v < 8; v++) begin
            run(VECS[v].rd, VECS[v].addr, VECS[v].cmd, int'(VECS[v].n), VECS[v].seed, 0);
            if (!VECS[v].rd) begin
                for (int i = 0; i < int'(VECS[v].n); i++)
                    check_mem("R3 written byte", 8'(VECS[v].addr) + 8'(i));
            end
            clr_flag();
        end

        // R5: interrupt gating and sticky flag
        irq_enable = 1'b1;
        run(1'b0, 16'h0080, 8'h11, 1, 8'h66, 0);
        chk("R5 irq when enabled", irq, 1'b1);
        irq_enable = 1'b0;
        wait_clk(1);
        chk("R5 irq masked", irq, 1'b0);
        run(1'b0, 16'h0081, 8'h00, 1, 8'h77, 0);
        chk("R5 flag kept over silent cmd", irq_flag, 1'b1);
        irq_enable = 1'b1;
        clr_flag();
        chk("R5 flag cleared", irq_flag, 1'b0);
        chk("R5 irq after clear", irq, 1'b0);
        irq_enable = 1'b0;

        // R4/R9: short transaction of two bytes
        tx_buf[0] = 8'h12;
        tx_buf[1] = 8'h34;
        spi_xfer(2, 0);
        exp_stat = {1'b0, 1'b0, (^8'h12) ^ (^8'h34), 3'b111, 2'b00};
        chk("R4 short keeps cmd_reg", cmd_reg, exp_cmd);
        chk("R4 short keeps flag", irq_flag, 1'b0);
        run(1'b1, 16'h0081, 8'h81, 1, 8'h00, 0);
        clr_flag();

        // R12: partial byte abort
        run(1'b0, 16'h0070, 8'h22, 2, 8'h19, 5);
        check_mem("R12 full byte 0 written", 8'h70);
        check_mem("R12 full byte 1 written", 8'h71);
        chk("R12 partial byte dropped", mem_arr[8'h72], 8'h72 ^ 8'h5A);
        clr_flag();
        run(1'b1, 16'h0070, 8'h82, 3, 8'h00, 0);
        clr_flag();

        // R10: safe window
        cfg_safe = 1'b1;
        run(1'b0, 16'h003F, 8'h33, 3, 8'hC0, 0);
        chk("R10 outside window dropped", mem_arr[8'h3F], 8'h3F ^ 8'h5A);
        check_mem("R10 inside window written", 8'h40);
        check_mem("R10 inside window written", 8'h41);
        clr_flag();
        run(1'b1, 16'h003F, 8'hB3, 3, 8'h00, 0);
        clr_flag();
        cfg_safe = 1'b0;

        // R6: memory not ready
        mem_ready = 1'b0;
        run(1'b0, 16'h0060, 8'h44, 2, 8'h90, 0);
        mem_ready = 1'b1;
        chk("R6 write suppressed", mem_arr[8'h60], 8'h60 ^ 8'h5A);
        clr_flag();
        run(1'b1, 16'h0060, 8'hC4, 2, 8'h00, 0);
        clr_flag();

        // R11: disabled port ignores bus
        cnt_before = we_cnt;
        cfg_enable = 1'b0;
        tx_buf[0] = 8'h00;
        tx_buf[1] = 8'h50;
        tx_buf[2] = 8'h85;
        tx_buf[3] = 8'hEE;
        spi_xfer(4, 0);
        chk("R11 miso idle", {rx_buf[0], rx_buf[1], rx_buf[2], rx_buf[3]}, 32'h0);
        chk("R11 no write", we_cnt, cnt_before);
        chk("R11 flag unchanged", irq_flag, 1'b0);
        chk("R11 cmd unchanged", cmd_reg, exp_cmd);
        cfg_enable = 1'b1;
        wait_clk(4);
        run(1'b1, 16'h0050, 8'h90, 1, 8'h00, 0);
        clr_flag();

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule